// File: doc/BRIEF.md
# 1-Wire Byte Master

This block is a memory-mapped master for a single-wire open-drain bus. Software reaches six byte-wide registers through a simple select/write-enable port. It can start three bus operations. The first is a reset pulse that reports whether any slave answered. The second sends a byte. The third is a byte read, which is the same byte transfer with every bit written as a one; the level sampled in each slot forms the received byte. Bus timing runs in ticks. A tick is one or more clock cycles, set by a divisor register, so the standard-speed time slots can be matched to any system clock.

Six status flags report on the block. Two belong to the reset operation: one marks that a reset has finished and one gives its result. Two cover transmit: one says the transmit buffer is empty and one says a transfer has finished. Two cover receive: one says the receive buffer is full and one says a second received byte is waiting behind it. Each flag can be enabled onto a single interrupt line whose active level is programmable. Reading the status register clears the two event flags. Reading the data register takes one byte out of the receive path. Register offsets are spaced by a power-of-two stride given as a parameter, so the block can sit on a wider bus.

Top module: `owm_byte_master`

## Requirements
- R1: The register index is address bits [BUS_SHIFT+2:BUS_SHIFT]. An access with any address bit below BUS_SHIFT set is ignored and reads 0. The indices are: command 0, data 1, status 2, interrupt enable 3, divisor 4, control 5. Indices 6 and 7 read 0. Enable, divisor and control read back what was written. After reset, status reads 0x04, the bus is released and the interrupt output is high.
- R2: Writing command with bit0 = 1 while the engine is idle holds the bus low for 480 ticks. Command bit0 reads 1 for the whole reset operation.
- R3: After the bus is released, the level is sampled 70 ticks later and the operation ends after 480 ticks high. At the end, status bit0 (reset done) is set and status bit1 is 1 when the sampled level was high (no slave) or 0 when a slave held the bus low.
- R4: Writing the data register sends 8 slots of 65 ticks each, least significant bit first. A 1 bit drives low for 6 ticks and a 0 bit for 60 ticks.
- R5: Each slot samples the bus 15 ticks after it starts. At the end of a transfer the sampled byte is loaded into the receive buffer and status bit4 (receive full) is set. Writing 0xFF therefore reads the slave's byte.
- R6: Reading the data register returns the receive buffer and clears bit4. If status bit5 is set, the held byte moves into the buffer instead: bit4 stays set and bit5 clears.
- R7: Reading status clears bit0 and bit3 (transfer done) and leaves the other bits unchanged, so an interrupt caused only by those bits is removed.
- R8: The interrupt is the OR of the status bits 0, 2, 3, 4 and 5 whose enable bit at the same position is set. Enable bit1 = 1 makes it active high; 0 inverts it.
- R9: Status bit2 (transmit empty) is 0 while a written byte waits for the engine, and the byte is sent when the engine becomes free. Bit3 is set only when a transfer ends with nothing queued. A transfer that ends while bit4 is set keeps its byte in a second stage and sets bit5.
- R10: Command bit2 pulls the bus low only while enable bit6 is 1; otherwise it has no effect. Command bit3 reads the synchronized bus level.
- R11: Writing command with bit5 = 1 aborts any operation, releases the bus, drops a queued byte and returns status to 0x04.
- R12: One tick lasts divisor+1 clock cycles, so with divisor 1 the reset low time is 960 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | BUS_SHIFT+3 | Byte address of the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt, programmable level |
| ow_pull_o | output | 1 | 1 = pull the bus low (open-drain enable) |
| ow_line_i | input | 1 | Sensed bus level |

## Verification
The bench goes after the places where flags collide:
- A second byte is queued behind a running one. A design that sets transfer-done twice, or loses the queued byte, shows the wrong status or the wrong second byte.
- A receive overflow into the second stage. A design that overwrites the first byte returns the second byte on the first data read.
- The stride decode with misaligned addresses. A design that ignores the low address bits corrupts the control register.
- A software reset in the middle of a reset pulse. A design that does not abort still raises presence-done about a millisecond later.

A slave model on the bench measures every low time and captures every bit from the wire. A slot length that is off by one tick, or a most-significant-first order, therefore shows up as a wrong pulse count or a wrong captured byte.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [2:0] {
    RI_CMD  = 3'd0,
    RI_DATA = 3'd1,
    RI_STAT = 3'd2,
    RI_IEN  = 3'd3,
    RI_DIV  = 3'd4,
    RI_CTRL = 3'd5
  } reg_idx_e;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_RLOW,
    EN_RHIGH,
    EN_SLOT
  } eng_st_e;

  typedef struct packed {
    logic rsrf;
    logic rbf;
    logic txd;
    logic tbe;
    logic pdr;
    logic pd;
  } flags_t;
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b1;
        else if (g == 0) stg_q[g] <= d_i;
        else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0)); // R12
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int T_RSTL = 480,
  parameter int T_PDS  = 70,
  parameter int T_REC  = 410,
  parameter int T_SLOT = 65,
  parameter int T_LOW1 = 6,
  parameter int T_LOW0 = 60,
  parameter int T_SAMP = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       abort_i,
  input  logic       rst_go_i,
  input  logic       byte_go_i,
  input  logic [7:0] tx_byte_i,
  input  logic       line_i,
  output logic       drive_o,
  output logic       busy_o,
  output logic       rst_busy_o,
  output logic       rst_done_o,
  output logic       present_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o
);
  localparam int TW = $clog2(T_RSTL + T_PDS + T_REC + T_SLOT + 1);
  localparam logic [TW-1:0] C_RLOW_END = TW'(T_RSTL - 1);
  localparam logic [TW-1:0] C_PDS      = TW'(T_PDS);
  localparam logic [TW-1:0] C_RHI_END  = TW'(T_PDS + T_REC - 1);
  localparam logic [TW-1:0] C_SLOT_END = TW'(T_SLOT - 1);
  localparam logic [TW-1:0] C_SAMP     = TW'(T_SAMP);
  localparam logic [TW-1:0] C_LOW1     = TW'(T_LOW1);
  localparam logic [TW-1:0] C_LOW0     = TW'(T_LOW0);

  eng_st_e       st_q;
  logic [TW-1:0] t_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;
  logic          pres_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= EN_IDLE;
      t_q         <= '0;
      bit_q       <= '0;
      tx_q        <= '0;
      rx_q        <= '0;
      pres_q      <= 1'b0;
      rst_done_o  <= 1'b0;
      byte_done_o <= 1'b0;
    end else begin
      rst_done_o  <= 1'b0;
      byte_done_o <= 1'b0;
      if (abort_i) begin
        st_q <= EN_IDLE;
        t_q  <= '0;
      end else begin
        unique case (st_q)
          EN_IDLE: begin
            t_q <= '0;
            if (rst_go_i) st_q <= EN_RLOW;
            else if (byte_go_i) begin
              st_q  <= EN_SLOT;
              bit_q <= '0;
              tx_q  <= tx_byte_i;
            end
          end
          EN_RLOW: if (tick_i) begin
            if (t_q == C_RLOW_END) begin
              st_q <= EN_RHIGH;
              t_q  <= '0;
            end else t_q <= t_q + 1'b1;
          end
          EN_RHIGH: if (tick_i) begin
            if (t_q == C_PDS) pres_q <= !line_i;
            if (t_q == C_RHI_END) begin
              st_q       <= EN_IDLE;
              t_q        <= '0;
              rst_done_o <= 1'b1;
            end else t_q <= t_q + 1'b1;
          end
          EN_SLOT: if (tick_i) begin
            if (t_q == C_SAMP) rx_q[bit_q] <= line_i;
            if (t_q == C_SLOT_END) begin
              t_q <= '0;
              if (bit_q == 3'd7) begin
                st_q        <= EN_IDLE;
                byte_done_o <= 1'b1;
              end else bit_q <= bit_q + 1'b1;
            end else t_q <= t_q + 1'b1;
          end
          default: st_q <= EN_IDLE;
        endcase
      end
    end
  end

  assign drive_o    = (st_q == EN_RLOW) ||
                      (st_q == EN_SLOT && t_q < (tx_q[bit_q] ? C_LOW1 : C_LOW0));
  assign busy_o     = (st_q != EN_IDLE);
  assign rst_busy_o = (st_q == EN_RLOW) || (st_q == EN_RHIGH);
  assign present_o  = pres_q;
  assign rx_byte_o  = rx_q;

  AST_RST_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rst_busy_o) && !$past(abort_i)) |-> rst_done_o); // R3
  AST_BYTE_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> (!busy_o || byte_go_i || rst_go_i || $past(byte_go_i))); // R4
endmodule

// File: rtl/owm_byte_master.sv
module owm_byte_master
  import owm_pkg::*;
#(
  parameter int BUS_SHIFT = 2,
  parameter int DIV_W     = 8,
  parameter int SYNC_STG  = 2,
  parameter int T_RSTL    = 480,
  parameter int T_PDS     = 70,
  parameter int T_REC     = 410,
  parameter int T_SLOT    = 65,
  parameter int T_LOW1    = 6,
  parameter int T_LOW0    = 60,
  parameter int T_SAMP    = 15
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_i,
  input  logic                 we_i,
  input  logic [BUS_SHIFT+2:0] addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 irq_o,
  output logic                 ow_pull_o,
  input  logic                 ow_line_i
);
  localparam int DIV_PAD = (DIV_W < 8) ? 8 - DIV_W : 0;

  logic       aligned;
  logic [2:0] idx;

  generate
    if (BUS_SHIFT > 0) begin : g_stride
      assign aligned = (addr_i[(BUS_SHIFT > 0 ? BUS_SHIFT-1 : 0):0] == '0);
    end else begin : g_nostride
      assign aligned = 1'b1;
    end
  endgenerate
  assign idx = addr_i[BUS_SHIFT +: 3];

  logic wr, rd, cmd_wr, data_wr, data_rd, stat_rd, swrst;
  assign wr      = cs_i && we_i && aligned;
  assign rd      = cs_i && !we_i && aligned;
  assign cmd_wr  = wr && idx == RI_CMD;
  assign data_wr = wr && idx == RI_DATA;
  assign data_rd = rd && idx == RI_DATA;
  assign stat_rd = rd && idx == RI_STAT;
  assign swrst   = cmd_wr && wdata_i[5];

  logic [7:0]       ien_q, ctrl_q, tx_buf_q, rx_buf_q, rx_hold_q;
  logic [DIV_W-1:0] div_q;
  logic             pend_q, force_q;
  flags_t           fl_q;

  logic       line_s, tick, eng_drive, eng_busy, eng_rbusy;
  logic       eng_rst_done, eng_present, eng_byte_done;
  logic [7:0] eng_rx;
  logic       rst_go, byte_go, rbf_after;

  assign rst_go  = cmd_wr && wdata_i[0] && !wdata_i[5] && !eng_busy;
  assign byte_go = pend_q && !eng_busy && !rst_go && !swrst;

  owm_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ow_line_i), .q_o(line_s)
  );

  owm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(eng_busy), .div_i(div_q), .tick_o(tick)
  );

  owm_engine #(
    .T_RSTL(T_RSTL), .T_PDS(T_PDS), .T_REC(T_REC), .T_SLOT(T_SLOT),
    .T_LOW1(T_LOW1), .T_LOW0(T_LOW0), .T_SAMP(T_SAMP)
  ) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .abort_i(swrst),
    .rst_go_i(rst_go), .byte_go_i(byte_go), .tx_byte_i(tx_buf_q),
    .line_i(line_s), .drive_o(eng_drive), .busy_o(eng_busy),
    .rst_busy_o(eng_rbusy), .rst_done_o(eng_rst_done), .present_o(eng_present),
    .byte_done_o(eng_byte_done), .rx_byte_o(eng_rx)
  );

  assign rbf_after = (data_rd && !fl_q.rsrf) ? 1'b0 : fl_q.rbf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q     <= '0;
      ctrl_q    <= '0;
      div_q     <= '0;
      tx_buf_q  <= '0;
      rx_buf_q  <= '0;
      rx_hold_q <= '0;
      pend_q    <= 1'b0;
      force_q   <= 1'b0;
      fl_q      <= '0;
    end else if (swrst) begin
      pend_q  <= 1'b0;
      force_q <= 1'b0;
      fl_q    <= '0;
    end else begin
      if (cmd_wr) force_q <= wdata_i[2];
      if (wr && idx == RI_IEN)  ien_q  <= wdata_i;
      if (wr && idx == RI_CTRL) ctrl_q <= wdata_i;
      if (wr && idx == RI_DIV)  div_q  <= wdata_i[DIV_W-1:0];
      if (data_wr) begin
        tx_buf_q <= wdata_i;
        pend_q   <= 1'b1;
        fl_q.txd <= 1'b0;
      end else if (byte_go) pend_q <= 1'b0;
      if (stat_rd) begin
        fl_q.pd  <= 1'b0;
        fl_q.txd <= 1'b0;
      end
      if (data_rd) begin
        if (fl_q.rsrf) begin
          rx_buf_q  <= rx_hold_q;
          fl_q.rsrf <= 1'b0;
        end else fl_q.rbf <= 1'b0;
      end
      if (eng_rst_done) begin
        fl_q.pd  <= 1'b1;
        fl_q.pdr <= !eng_present;
      end
      if (eng_byte_done) begin
        if (!pend_q && !data_wr) fl_q.txd <= 1'b1;
        if (!rbf_after) begin
          rx_buf_q <= eng_rx;
          fl_q.rbf <= 1'b1;
        end else begin
          rx_hold_q <= eng_rx;
          fl_q.rsrf <= 1'b1;
        end
      end
    end
  end

  flags_t fl_view;
  always_comb begin
    fl_view     = fl_q;
    fl_view.tbe = !pend_q;
  end

  logic irq_any;
  assign irq_any   = |({fl_view.rsrf, fl_view.rbf, fl_view.txd, fl_view.tbe, 1'b0, fl_view.pd}
                       & {ien_q[5:2], 1'b0, ien_q[0]});
  assign irq_o     = ien_q[1] ? irq_any : !irq_any;
  assign ow_pull_o = eng_drive || (force_q && ien_q[6]);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (idx)
        RI_CMD:  rdata_o = {4'b0, line_s, 2'b0, eng_rbusy};
        RI_DATA: rdata_o = rx_buf_q;
        RI_STAT: rdata_o = {2'b0, fl_view};
        RI_IEN:  rdata_o = ien_q;
        RI_DIV:  rdata_o = 8'({{DIV_PAD{1'b0}}, div_q});
        RI_CTRL: rdata_o = ctrl_q;
        default: rdata_o = '0;
      endcase
    end
  end

  AST_SWRST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst |=> !ow_pull_o); // R11
  AST_RBF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !fl_q.rsrf && !eng_byte_done) |=> !fl_q.rbf); // R6
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !eng_rst_done && !eng_byte_done) |=> (!fl_q.pd && !fl_q.txd)); // R7
  AST_PD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_q.pd) |-> $past(eng_rst_done)); // R3
  AST_BYTE_START: assert property (@(posedge clk_i) disable iff (!rst_ni || swrst)
    (data_wr && !eng_busy && !pend_q) |=> ##1 eng_busy); // R4
  AST_FORCE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_q[6] && !eng_busy) |-> !ow_pull_o); // R10
endmodule

// File: tb/tb_owm_byte_master.sv
module tb_owm_byte_master;
  localparam int SH = 2;
  localparam logic [2:0] I_CMD = 0, I_DATA = 1, I_STAT = 2, I_IEN = 3, I_DIV = 4, I_CTRL = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [SH+2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, pull, slave_pull = 1'b0;
  wire  line = !(pull || slave_pull);

  always #10 clk = !clk;

  owm_byte_master #(.BUS_SHIFT(SH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .ow_pull_o(pull), .ow_line_i(line)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // slave model
  bit sl_en = 1'b0, sl_rst_mode = 1'b0, sl_present = 1'b1;
  logic [15:0] sl_tx = '1, sl_mtx = '1, sl_rx = '0;
  int sl_idx = 0, sl_low_err = 0, rst_low_len = 0, sc = 1;

  initial begin
    forever begin
      @(negedge clk);
      if (sl_en && pull) begin
        int cnt;
        bit still;
        cnt = 1;
        if (sl_rst_mode) begin
          while (pull) begin
            @(negedge clk);
            if (pull) cnt++;
          end
          rst_low_len = cnt;
          repeat (20*sc) @(negedge clk);
          if (sl_present) slave_pull = 1'b1;
          repeat (100*sc) @(negedge clk);
          slave_pull = 1'b0;
        end else begin
          still = 1'b1;
          if (!sl_tx[sl_idx[3:0]]) slave_pull = 1'b1;
          for (int k = 1; k < 30*sc; k++) begin
            @(negedge clk);
            if (still && pull) cnt++;
            else still = 1'b0;
          end
          sl_rx[sl_idx[3:0]] = line;
          slave_pull = 1'b0;
          while (pull) begin
            @(negedge clk);
            if (still && pull) cnt++;
          end
          if (cnt != (sl_mtx[sl_idx[3:0]] ? 6*sc : 60*sc)) sl_low_err++;
          sl_idx++;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [SH+2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd_a(input logic [SH+2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic wr(input logic [2:0] i, input logic [7:0] d);
    wr_a({i, {SH{1'b0}}}, d);
  endtask

  task automatic rd(input logic [2:0] i, output logic [7:0] d);
    rd_a({i, {SH{1'b0}}}, d);
  endtask

  task automatic wait_irq(input string req);
    int n;
    n = 0;
    while (irq !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(req, int'(irq === 1'b1), 1);
  endtask

  function automatic logic [7:0] stat(bit rsrf, bit rbf, bit txd, bit tbe, bit pdr, bit pd);
    return {2'b00, rsrf, rbf, txd, tbe, pdr, pd};
  endfunction

  function automatic logic exp_irq(logic [7:0] st, logic [7:0] en);
    logic any;
    any = |(st & en & 8'h3D);
    return en[1] ? any : !any;
  endfunction

  bit exp_pdr = 1'b0;

  task automatic do_reset_op(input bit present, input string req);
    logic [7:0] v;
    sl_rst_mode = 1'b1; sl_present = present;
    wr(I_IEN, 8'h03);
    wr(I_CMD, 8'h01);
    rd(I_CMD, v);
    chk("R2 busy bit", int'(v[0]), 1);
    wait_irq(req);
    exp_pdr = !present;
    rd(I_STAT, v);
    chk("R3 status after reset", v, stat(0, 0, 0, 1, !present, 1));
    @(negedge clk);
    chk("R7 irq cleared by status read", irq, 0);
    rd(I_STAT, v);
    chk("R7 pd cleared", v, stat(0, 0, 0, 1, !present, 0));
  endtask

  task automatic do_xfer(input logic [7:0] m, input logic [7:0] s);
    logic [7:0] v;
    sl_rst_mode = 1'b0;
    sl_mtx = {8'hFF, m}; sl_tx = {8'hFF, s}; sl_idx = 0; sl_low_err = 0;
    wr(I_IEN, 8'h0A);
    wr(I_DATA, m);
    wait_irq("R4 transfer done");
    chk("R4 bits seen on wire LSB first", sl_rx[7:0], m & s);
    chk("R4 slot low times", sl_low_err, 0);
    rd(I_STAT, v);
    chk("R5 status after transfer", v, stat(0, 1, 1, 1, exp_pdr, 0));
    rd(I_DATA, v);
    chk("R5 received byte", v, m & s);
    rd(I_STAT, v);
    chk("R6 rbf cleared", v, stat(0, 0, 0, 1, exp_pdr, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, m, s, s2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values and decode
    rd(I_STAT, v);  chk("R1 reset status", v, 8'h04);
    chk("R1 reset irq level", irq, 1);
    chk("R1 reset bus released", pull, 0);
    wr(I_CTRL, 8'hA5);
    rd(I_CTRL, v);  chk("R1 control readback", v, 8'hA5);
    wr_a({I_CTRL, 2'b01}, 8'h3C);
    rd(I_CTRL, v);  chk("R1 misaligned write ignored", v, 8'hA5);
    rd_a({I_CTRL, 2'b10}, v); chk("R1 misaligned read zero", v, 0);
    rd(3'd6, v);    chk("R1 unused index", v, 0);
    wr(I_DIV, 8'h00);
    rd(I_DIV, v);   chk("R1 divisor readback", v, 0);

    // R8 polarity
    wr(I_IEN, 8'h04); @(negedge clk); chk("R8 tbe active low", irq, exp_irq(8'h04, 8'h04));
    wr(I_IEN, 8'h06); @(negedge clk); chk("R8 tbe active high", irq, exp_irq(8'h04, 8'h06));
    wr(I_IEN, 8'h02); @(negedge clk); chk("R8 nothing enabled high", irq, 0);
    wr(I_IEN, 8'h00); @(negedge clk); chk("R8 nothing enabled low", irq, 1);

    // R2 R3 reset operations
    sl_en = 1'b1;
    do_reset_op(1'b1, "R3 present done");
    chk("R2 reset low length", rst_low_len, 480);
    do_reset_op(1'b0, "R3 absent done");

    // R12 divisor
    wr(I_DIV, 8'h01); sc = 2;
    do_reset_op(1'b1, "R12 slow reset done");
    chk("R12 reset low length", rst_low_len, 960);
    wr(I_DIV, 8'h00); sc = 1;

    // R4 R5 directed and random transfers
    do_xfer(8'hA5, 8'hFF);
    do_xfer(8'h01, 8'hFF);
    do_xfer(8'hFF, 8'h3C);
    for (int it = 0; it < 6; it++) begin
      m = (it % 2 == 0) ? 8'hFF : 8'($urandom);
      s = 8'($urandom);
      do_xfer(m, s);
    end

    // R9 queued byte and second stage
    s = 8'($urandom); s2 = 8'($urandom);
    sl_mtx = '1; sl_tx = {s2, s}; sl_idx = 0; sl_low_err = 0;
    wr(I_IEN, 8'h0A);
    wr(I_DATA, 8'hFF);
    wr(I_DATA, 8'hFF);
    rd(I_STAT, v);  chk("R9 tbe low while queued", v, stat(0, 0, 0, 0, exp_pdr, 0));
    wait_irq("R9 both done");
    rd(I_STAT, v);  chk("R9 second stage full", v, stat(1, 1, 1, 1, exp_pdr, 0));
    rd(I_DATA, v);  chk("R6 first byte", v, s);
    rd(I_STAT, v);  chk("R6 held byte moved", v, stat(0, 1, 0, 1, exp_pdr, 0));
    rd(I_DATA, v);  chk("R6 second byte", v, s2);
    rd(I_STAT, v);  chk("R6 all empty", v, stat(0, 0, 0, 1, exp_pdr, 0));

    // R10 force low
    sl_en = 1'b0;
    wr(I_IEN, 8'h00);
    wr(I_CMD, 8'h04);
    repeat (4) @(negedge clk);
    chk("R10 force ignored", pull, 0);
    rd(I_CMD, v);   chk("R10 level high", int'(v[3]), 1);
    wr(I_IEN, 8'h40);
    wr(I_CMD, 8'h04);
    repeat (4) @(negedge clk);
    chk("R10 force applied", pull, 1);
    rd(I_CMD, v);   chk("R10 level low", int'(v[3]), 0);
    wr(I_CMD, 8'h00);
    repeat (4) @(negedge clk);
    chk("R10 released", pull, 0);

    // R11 software reset mid reset pulse
    sl_en = 1'b1; sl_rst_mode = 1'b1; sl_present = 1'b1;
    wr(I_IEN, 8'h00);
    wr(I_CMD, 8'h01);
    repeat (100) @(negedge clk);
    wr(I_CMD, 8'h20);
    chk("R11 bus released", pull, 0);
    rd(I_CMD, v);   chk("R11 not busy", int'(v[0]), 0);
    repeat (1200) @(negedge clk);
    rd(I_STAT, v);  chk("R11 status cleared", v, 8'h04);
    exp_pdr = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule